// File: doc/BRIEF.md
# Wake-up Exit Delay Sequencer

This block decides the cycle on which a processor core may execute again after a wake event ends a low-power state. A request from the running core records which kind of low-power state is being entered and takes away the run enable. The block then waits for a wake event. When one arrives, it looks at the recorded state and at the clock that will drive the core after wake-up, and it starts the delays that this pair calls for.

A fixed core-preparation delay starts on every wake. Beside it, at most one oscillator-related delay also runs. A crystal source needs its start-up time. A crystal source feeding a frequency multiplier needs its start-up time plus a lock time. A fast internal oscillator that was stopped needs a settling time, and this one does not hold execution back. Every other source needs nothing more than the preparation delay. The core is released only when the preparation delay and any delay that holds execution back have both run out.

Two status outputs track the oscillators. One reports that the crystal or multiplied crystal has finished starting. The other reports that the fast internal oscillator has settled. All durations are parameters counted in cycles of the block's clock.

Top module: `wake_exit_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `cpu_run`, `osc_rdy` and `int_stable` are 0. The block waits for a wake event as if it had entered Sleep (lp_mode 0).
- R2: When `lp_enter` is sampled high while `cpu_run` is 1, `cpu_run` is 0 from the next cycle. The value of `lp_mode` sampled on that edge is stored as the state being entered: 0 Sleep, 1 idle on primary clock, 2 idle on fast internal oscillator, 3 idle on another clock.
- R3: Let edge k be the edge that samples a wake. `cpu_run` is never 1 earlier than TCSD+1 cycles after edge k. When no other delay holds execution back, `cpu_run` becomes 1 exactly TCSD+1 cycles after edge k.
- R4: After idle on the primary clock (lp_mode 1), only the preparation delay applies, whatever `clk_sel` is, and neither status flag changes.
- R5: After any state other than lp_mode 1 with `clk_sel` 0 (crystal), `cpu_run` rises max(TCSD,TOST)+1 cycles after edge k. `osc_rdy` is 0 from the cycle after edge k and becomes 1 on the cycle in which `cpu_run` rises.
- R6: After any state other than lp_mode 1 with `clk_sel` 1 (crystal with multiplier), `osc_rdy` is cleared in the same way as in R5. `cpu_run` and `osc_rdy` then rise together max(TCSD,TOST+TPLL)+1 cycles after edge k.
- R7: With `clk_sel` 2 (external clock or RC), 3 (low-frequency internal RC) or 5 to 7 (treated as 2), only the preparation delay applies and neither flag changes.
- R8: With `clk_sel` 4 (fast internal oscillator) after lp_mode 0 or 3, `cpu_run` rises TCSD+1 cycles after edge k. `int_stable` is 0 from the cycle after edge k and becomes 1 exactly TIOBST+1 cycles after edge k, even if the core is already running by then.
- R9: With `clk_sel` 4 after lp_mode 2, only the preparation delay applies and `int_stable` keeps its value.
- R10: `lp_enter` has no effect while `cpu_run` is 0. A wake has no effect while `cpu_run` is 1 or while an exit delay is in progress, and `cpu_run` stays 1 until an `lp_enter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that paces all delays |
| rst | input | 1 | Synchronous reset, active high |
| lp_enter | input | 1 | Request from the running core to enter a low-power state |
| lp_mode | input | 2 | Kind of low-power state being entered (0 Sleep, 1 primary idle, 2 fast-internal idle, 3 other idle) |
| wake | input | 1 | Wake event |
| clk_sel | input | 3 | Clock source after wake-up (0 crystal, 1 crystal with multiplier, 2 external/RC, 3 low-frequency RC, 4 fast internal) |
| cpu_run | output | 1 | Core may execute |
| osc_rdy | output | 1 | Crystal or multiplied crystal has finished starting |
| int_stable | output | 1 | Fast internal oscillator has settled |

## Verification
The hardest situation to reach is a second wake, together with a new low-power request, arriving in the middle of a long crystal exit. Either one, if wrongly accepted, would restart the delay or change the stored state. The stimulus starts a crystal exit and pulses both inputs a few cycles into the wait. The release is then checked on the original cycle. The other hard case is the internal oscillator's settling flag, which rises many cycles after the core is already running. To catch it, the scoreboard keeps expectations dated well past the run-enable rise, and a following wake from fast-internal idle shows that the flag is kept.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

    typedef enum logic [1:0] {
        LPM_SLEEP      = 2'd0,
        LPM_PRI_IDLE   = 2'd1,
        LPM_IDLE_HFINT = 2'd2,
        LPM_IDLE_OTHER = 2'd3
    } lp_mode_e;

    typedef enum logic [2:0] {
        CS_XTAL     = 3'd0,
        CS_XTAL_PLL = 3'd1,
        CS_EXT_RC   = 3'd2,
        CS_LFRC     = 3'd3,
        CS_HFINT    = 3'd4
    } clk_sel_e;

    typedef enum logic [1:0] {
        DLY_NONE    = 2'd0,
        DLY_OST     = 2'd1,
        DLY_OST_PLL = 2'd2,
        DLY_STAB    = 2'd3
    } dly_cls_e;

    typedef enum logic [1:0] {
        ST_LOWPWR = 2'd0,
        ST_EXIT   = 2'd1,
        ST_RUN    = 2'd2
    } seq_st_e;

    // Context latched when a wake is accepted
    typedef struct packed {
        lp_mode_e mode;
        dly_cls_e cls;
    } wake_ctx_t;

    // Counter slots
    localparam int NCNT     = 3;
    localparam int CNT_PREP = 0;
    localparam int CNT_BLK  = 1;
    localparam int CNT_STAB = 2;

    function automatic dly_cls_e classify(lp_mode_e m, logic [2:0] sel);
        dly_cls_e c;
        c = DLY_NONE;
        if (m != LPM_PRI_IDLE) begin
            case (sel)
                CS_XTAL:     c = DLY_OST;
                CS_XTAL_PLL: c = DLY_OST_PLL;
                CS_HFINT:    c = (m == LPM_IDLE_HFINT) ? DLY_NONE : DLY_STAB;
                default:     c = DLY_NONE;
            endcase
        end
        return c;
    endfunction

    function automatic logic uses_xtal(dly_cls_e c);
        return (c == DLY_OST) || (c == DLY_OST_PLL);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wake_dly_counter.sv
module wake_dly_counter #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wake_exit_ctrl.sv
module wake_exit_ctrl
    import wake_seq_pkg::*;
#(
    parameter int CW   = 6,
    parameter int TOST = 20,
    parameter int TPLL = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lp_enter,
    input  logic [1:0]    lp_mode,
    input  logic          wake,
    input  logic [2:0]    clk_sel,
    input  logic          prep_zero,
    input  logic          blk_zero,
    input  logic          stab_zero,
    output logic          cpu_run,
    output logic          osc_rdy,
    output logic          int_stable,
    output logic          wake_acc,
    output logic          load_stab,
    output logic [CW-1:0] blk_val,
    output logic          in_exit
);
    localparam logic [CW-1:0] OST_V = CW'(TOST);
    localparam logic [CW-1:0] PLL_V = CW'(TOST + TPLL);

    seq_st_e   st;
    wake_ctx_t ctx;
    dly_cls_e  cls_now;
    logic      exit_done;
    logic      stab_pend;

    assign cls_now   = classify(ctx.mode, clk_sel);
    assign wake_acc  = (st == ST_LOWPWR) && wake;
    assign in_exit   = (st == ST_EXIT);
    assign exit_done = in_exit && prep_zero && blk_zero;
    assign load_stab = wake_acc && (cls_now == DLY_STAB);
    assign cpu_run   = (st == ST_RUN);

    always_comb begin
        case (cls_now)
            DLY_OST:     blk_val = OST_V;
            DLY_OST_PLL: blk_val = PLL_V;
            default:     blk_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_LOWPWR;
            ctx.mode <= LPM_SLEEP;
            ctx.cls  <= DLY_NONE;
        end else begin
            case (st)
                ST_RUN: begin
                    if (lp_enter) begin
                        st       <= ST_LOWPWR;
                        ctx.mode <= lp_mode_e'(lp_mode);
                    end
                end
                ST_LOWPWR: begin
                    if (wake) begin
                        st      <= ST_EXIT;
                        ctx.cls <= cls_now;
                    end
                end
                ST_EXIT: begin
                    if (exit_done) st <= ST_RUN;
                end
                default: st <= ST_LOWPWR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_rdy <= 1'b0;
        end else if (wake_acc && uses_xtal(cls_now)) begin
            osc_rdy <= 1'b0;
        end else if (exit_done && uses_xtal(ctx.cls)) begin
            osc_rdy <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_stable <= 1'b0;
            stab_pend  <= 1'b0;
        end else if (load_stab) begin
            int_stable <= 1'b0;
            stab_pend  <= 1'b1;
        end else if (stab_pend && stab_zero) begin
            int_stable <= 1'b1;
            stab_pend  <= 1'b0;
        end
    end
endmodule

// File: rtl/wake_exit_seq.sv
module wake_exit_seq
    import wake_seq_pkg::*;
#(
    parameter int TCSD   = 4,
    parameter int TOST   = 20,
    parameter int TPLL   = 10,
    parameter int TIOBST = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_enter,
    input  logic [1:0] lp_mode,
    input  logic       wake,
    input  logic [2:0] clk_sel,
    output logic       cpu_run,
    output logic       osc_rdy,
    output logic       int_stable
);
    localparam int unsigned MAXD = max3(TCSD, TOST + TPLL, TIOBST);
    localparam int          CW   = (MAXD < 2) ? 1 : $clog2(MAXD + 1);

    logic              wake_acc;
    logic              load_stab;
    logic              in_exit;
    logic [CW-1:0]     blk_val;
    logic [NCNT-1:0]   cnt_ld;
    logic [NCNT-1:0]   cnt_zero;
    logic [CW-1:0]     cnt_val [NCNT];

    assign cnt_ld[CNT_PREP]  = wake_acc;
    assign cnt_ld[CNT_BLK]   = wake_acc;
    assign cnt_ld[CNT_STAB]  = load_stab;
    assign cnt_val[CNT_PREP] = CW'(TCSD);
    assign cnt_val[CNT_BLK]  = blk_val;
    assign cnt_val[CNT_STAB] = CW'(TIOBST);

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        wake_dly_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (cnt_ld[g]),
            .load_val (cnt_val[g]),
            .zero     (cnt_zero[g])
        );
    end

    wake_exit_ctrl #(.CW(CW), .TOST(TOST), .TPLL(TPLL)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lp_enter   (lp_enter),
        .lp_mode    (lp_mode),
        .wake       (wake),
        .clk_sel    (clk_sel),
        .prep_zero  (cnt_zero[CNT_PREP]),
        .blk_zero   (cnt_zero[CNT_BLK]),
        .stab_zero  (cnt_zero[CNT_STAB]),
        .cpu_run    (cpu_run),
        .osc_rdy    (osc_rdy),
        .int_stable (int_stable),
        .wake_acc   (wake_acc),
        .load_stab  (load_stab),
        .blk_val    (blk_val),
        .in_exit    (in_exit)
    );
endmodule

// File: rtl/wake_exit_seq_chk.sv
module wake_exit_seq_chk #(
    parameter int TCSD = 4
) (
    input logic clk,
    input logic rst,
    input logic lp_enter,
    input logic wake,
    input logic cpu_run,
    input logic osc_rdy,
    input logic int_stable,
    input logic wake_acc,
    input logic in_exit
);
    int exit_cnt;

    always_ff @(posedge clk) begin
        if (rst)          exit_cnt <= 0;
        else if (in_exit) exit_cnt <= exit_cnt + 1;
        else              exit_cnt <= 0;
    end

    p_run_drop_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_run && lp_enter |=> !cpu_run);

    p_run_hold_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_run && !lp_enter |=> cpu_run);

    p_no_wake_no_run_r10: assert property (@(posedge clk) disable iff (rst)
        !cpu_run && !in_exit && !wake |=> !cpu_run);

    p_min_exit_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_run) |-> exit_cnt >= TCSD + 1);

    p_osc_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_rdy) |-> $past(wake_acc));

    p_osc_set_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_rdy) |-> $rose(cpu_run));

    p_int_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(int_stable) |-> $past(wake_acc));
endmodule

bind wake_exit_seq wake_exit_seq_chk #(.TCSD(TCSD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lp_enter   (lp_enter),
    .wake       (wake),
    .cpu_run    (cpu_run),
    .osc_rdy    (osc_rdy),
    .int_stable (int_stable),
    .wake_acc   (wake_acc),
    .in_exit    (in_exit)
);

// File: tb/wake_exit_seq_bench.sv
module wake_exit_seq_bench;
    localparam int TCSD   = 4;
    localparam int TOST   = 20;
    localparam int TPLL   = 10;
    localparam int TIOBST = 30;
    localparam int L_PREP = TCSD + 1;
    localparam int L_XTAL = ((TOST > TCSD) ? TOST : TCSD) + 1;
    localparam int L_PLL  = ((TOST + TPLL > TCSD) ? TOST + TPLL : TCSD) + 1;
    localparam int L_STAB = TIOBST + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_enter = 1'b0;
    logic [1:0] lp_mode = 2'd0;
    logic       wake = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       cpu_run, osc_rdy, int_stable;

    wake_exit_seq #(.TCSD(TCSD), .TOST(TOST), .TPLL(TPLL), .TIOBST(TIOBST)) u_wake_exit_seq (
        .clk(clk), .rst(rst), .lp_enter(lp_enter), .lp_mode(lp_mode),
        .wake(wake), .clk_sel(clk_sel),
        .cpu_run(cpu_run), .osc_rdy(osc_rdy), .int_stable(int_stable)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  run;
        bit    use_osc;
        logic  osc;
        bit    use_ist;
        logic  ist;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    task automatic push(int at, logic run, bit uo, logic osc, bit ui, logic ist, string tag);
        exp_t e;
        e.at = at; e.run = run; e.use_osc = uo; e.osc = osc;
        e.use_ist = ui; e.ist = ist; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares scoreboard items on their due cycle
    always @(negedge clk) begin : mon
        exp_t e;
        bit   ok;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            n_chk++;
            ok = (e.at == cyc) && (cpu_run === e.run)
                 && (!e.use_osc || osc_rdy === e.osc)
                 && (!e.use_ist || int_stable === e.ist);
            if (!ok) begin
                n_bad++;
                $display("FAIL %s cyc %0d: run/osc/ist actual %b/%b/%b expected %b/%b/%b",
                         e.tag, cyc, cpu_run, osc_rdy, int_stable, e.run,
                         e.use_osc ? e.osc : osc_rdy, e.use_ist ? e.ist : int_stable);
            end
        end
    end

    task automatic go_low(logic [1:0] m);
        @(negedge clk);
        lp_mode  = m;
        lp_enter = 1'b1;
        push(cyc + 1, 1'b0, 0, 1'b0, 0, 1'b0, "R2");
        @(negedge clk);
        lp_enter = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Wake with clock selection sel; run expected lat cycles after the sampling edge.
    // stab > 0: int_stable expected to rise stab cycles after that edge.
    task automatic wake_up(logic [2:0] sel, int lat, int stab,
                           bit uo, logic o_mid, logic o_fin,
                           bit ui, logic i_mid, logic i_fin,
                           bit poke, string tag);
        int k;
        int span;
        @(negedge clk);
        clk_sel = sel;
        wake    = 1'b1;
        k       = cyc + 1;
        push(k, 1'b0, uo, o_mid, ui, i_mid, tag);
        push(k + lat - 1, 1'b0, 0, 1'b0, 0, 1'b0, tag);
        push(k + lat, 1'b1, uo, o_fin, ui && (stab == 0), i_fin, tag);
        if (stab > 0) begin
            push(k + stab - 1, 1'b1, 0, 1'b0, ui, i_mid, tag);
            push(k + stab, 1'b1, 0, 1'b0, ui, i_fin, tag);
        end
        span = ((stab > lat) ? stab : lat) + 3;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (poke && i == 2) begin
                wake     = 1'b1;
                lp_enter = 1'b1;
                lp_mode  = 2'd1;
            end else begin
                wake     = 1'b0;
                lp_enter = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, first cycle after release
        push(cyc + 1, 1'b0, 1, 1'b0, 1, 1'b0, "R1");
        repeat (2) @(negedge clk);

        // R10: lp_enter while not running is ignored (mode stays Sleep)
        @(negedge clk);
        lp_mode  = 2'd1;
        lp_enter = 1'b1;
        push(cyc + 1, 1'b0, 1, 1'b0, 1, 1'b0, "R10");
        @(negedge clk);
        lp_enter = 1'b0;
        repeat (2) @(negedge clk);

        // R5: crystal from Sleep (reset state); would be short if R10 were broken
        wake_up(3'd0, L_XTAL, 0, 1, 1'b0, 1'b1, 1, 1'b0, 1'b0, 0, "R5");

        // R6: crystal with multiplier from Sleep
        go_low(2'd0);
        wake_up(3'd1, L_PLL, 0, 1, 1'b0, 1'b1, 1, 1'b0, 1'b0, 0, "R6");

        // R4: primary idle, crystal selected: preparation only, flag kept
        go_low(2'd1);
        wake_up(3'd0, L_PREP, 0, 1, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, "R4");
        go_low(2'd1);
        wake_up(3'd4, L_PREP, 0, 1, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, "R4");

        // R7: external/RC and reserved code, other-clock idle
        go_low(2'd3);
        wake_up(3'd2, L_PREP, 0, 1, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, "R7");
        go_low(2'd3);
        wake_up(3'd6, L_PREP, 0, 1, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, "R7");

        // R3: low-frequency RC from Sleep, exact preparation latency
        go_low(2'd0);
        wake_up(3'd3, L_PREP, 0, 1, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, "R3");

        // R8: fast internal oscillator from Sleep
        go_low(2'd0);
        wake_up(3'd4, L_PREP, L_STAB, 1, 1'b1, 1'b1, 1, 1'b0, 1'b1, 0, "R8");

        // R9: fast internal oscillator from its own idle: flag kept
        go_low(2'd2);
        wake_up(3'd4, L_PREP, 0, 1, 1'b1, 1'b1, 1, 1'b1, 1'b1, 0, "R9");

        // R10: wake while running has no effect
        @(negedge clk);
        clk_sel = 3'd0;
        wake    = 1'b1;
        push(cyc + 1, 1'b1, 1, 1'b1, 1, 1'b1, "R10");
        push(cyc + 2, 1'b1, 1, 1'b1, 1, 1'b1, "R10");
        @(negedge clk);
        wake = 1'b0;
        repeat (3) @(negedge clk);

        // R10: wake and lp_enter during a crystal exit are ignored
        go_low(2'd0);
        wake_up(3'd0, L_XTAL, 0, 1, 1'b0, 1'b1, 1, 1'b1, 1'b1, 1, "R10");

        // R8: fast internal oscillator after other-clock idle
        go_low(2'd3);
        wake_up(3'd4, L_PREP, L_STAB, 1, 1'b1, 1'b1, 1, 1'b0, 1'b1, 0, "R8");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
        end
        finish_run();
    end
endmodule